// File: doc/BRIEF.md
# Parallel Prefix Adder

This block is a purely combinational N-bit adder. It takes two N-bit operands and an incoming carry, and it returns an N-bit sum and an outgoing carry. N must be a power of two and defaults to 16.

The incoming carry is modelled as one extra column that sits below bit 0. That column has a generate equal to the carry and a propagate of zero. Every real column first forms its own generate and propagate terms. A tree of prefix cells then merges these terms over spans that double in width at each level, so log2N levels are enough. After the last level, each column knows whether a carry arrives into it. A final XOR of the two operand bits with that carry gives each sum bit. One more merge above the top column gives the outgoing carry.

Top module: `ppa_adder`

## Requirements
- R1: For every input, {carryOut, sum} equals opA + opB + carryIn taken as an (N+1)-bit unsigned result.
- R2: The column generate is opA[i] AND opB[i]. With USE_XOR_PROP = 0 the column propagate is opA[i] OR opB[i]; with USE_XOR_PROP = 1 it is opA[i] XOR opB[i]. Both settings give identical sum and carryOut.
- R3: carryIn acts as a column below bit 0. With both operands zero, sum equals carryIn placed in bit 0 and carryOut is 0.
- R4: A carry entering at carryIn crosses every column. All-ones opA with opB = 0 and carryIn = 1 gives sum = 0 and carryOut = 1.
- R5: carryOut is the generate of the span from column N-1 down to the carry-in column. It is 1 whenever the top column generates, as with both operands all ones.
- R6: A sum bit depends only on its own column and the columns below it. Flipping opA[N-1] changes no bit of sum[N-2:0].
- R7: The prefix tree has log2N levels, and after the last level every span that reaches the carry-in column has propagate 0. With N = 4 the adder meets R1 over all 512 input combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | N | First operand |
| opB | input | N | Second operand |
| carryIn | input | 1 | Incoming carry, treated as the column below bit 0 |
| sum | output | N | Sum bits |
| carryOut | output | 1 | Carry out of the top column |

## Verification
The bench builds the adder three times. At N = 4, every operand pair and carry value fits in 512 vectors, so the small instance is checked exhaustively. At N = 16, a table of carry-chain corner vectors and a random sweep exercise full-length carry ripples through all four prefix levels. A third N = 16 instance uses the XOR propagate variant, and each of its results is compared with the OR variant for the same stimulus.

// File: rtl/ppa_adder_pkg.sv
package ppa_adder_pkg;

  typedef struct packed {
    logic gen;
    logic prop;
  } spanT;

  // Black prefix cell: upper span hi merged with the lower span lo below it.
  function automatic spanT mergeSpan(input spanT hi, input spanT lo);
    spanT r;
    r.gen  = hi.gen | (hi.prop & lo.gen);
    r.prop = hi.prop & lo.prop;
    return r;
  endfunction

endpackage

// File: rtl/ppa_column_pg.sv
module ppa_column_pg #(
  parameter int N = 16,
  parameter bit USE_XOR_PROP = 1'b0
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [N-1:0] colGen,
  output logic [N-1:0] colProp
);

  assign colGen = opA & opB;

  generate
    if (USE_XOR_PROP) begin : g_xorProp
      assign colProp = opA ^ opB;
    end else begin : g_orProp
      assign colProp = opA | opB;
    end
  endgenerate

  // A column that generates never has both operand bits clear (R2).
  always_comb begin
    assert_gen_has_operands_R2: assert ((colGen & ~(opA | opB)) == '0)
      else $error("column generate without operand bits");
  end

endmodule

// File: rtl/ppa_prefix_tree.sv
module ppa_prefix_tree
  import ppa_adder_pkg::*;
#(
  parameter int N = 16,
  localparam int LEVELS = $clog2(N)
) (
  input  logic [N-1:0] leafGen,   // index 0 is the carry-in column
  input  logic [N-1:0] leafProp,
  output logic [N-1:0] spanGen    // spanGen[k]: generate of span k-1..-1
);

  logic [N-1:0] gLvl [0:LEVELS];
  logic [N-1:0] pLvl [0:LEVELS];

  assign gLvl[0] = leafGen;
  assign pLvl[0] = leafProp;

  generate
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
      localparam int DIST = 1 << lv;
      for (genvar k = 0; k < N; k++) begin : g_node
        if (k >= DIST) begin : g_cell
          spanT merged;
          assign merged = mergeSpan('{gen: gLvl[lv][k], prop: pLvl[lv][k]},
                                    '{gen: gLvl[lv][k-DIST], prop: pLvl[lv][k-DIST]});
          assign gLvl[lv+1][k] = merged.gen;
          assign pLvl[lv+1][k] = merged.prop;
        end else begin : g_pass
          assign gLvl[lv+1][k] = gLvl[lv][k];
          assign pLvl[lv+1][k] = pLvl[lv][k];
        end
      end
    end
  endgenerate

  assign spanGen = gLvl[LEVELS];

  // Every finished span reaches the carry-in column, whose propagate is zero (R7).
  always_comb begin
    if (leafProp[0] == 1'b0) begin
      assert_span_prop_zero_R7: assert (pLvl[LEVELS] == '0)
        else $error("span reaching carry-in column has nonzero propagate");
    end
  end

endmodule

// File: rtl/ppa_sum_stage.sv
module ppa_sum_stage #(
  parameter int N = 16
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic [N-1:0] carryInto,
  input  logic         topGen,
  input  logic         topProp,
  output logic [N-1:0] sum,
  output logic         carryOut
);

  assign sum      = opA ^ opB ^ carryInto;
  assign carryOut = topGen | (topProp & carryInto[N-1]);

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder #(
  parameter int N = 16,
  parameter bit USE_XOR_PROP = 1'b0
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         carryIn,
  output logic [N-1:0] sum,
  output logic         carryOut
);

  logic [N-1:0] colGen;
  logic [N-1:0] colProp;
  logic [N-1:0] leafGen;
  logic [N-1:0] leafProp;
  logic [N-1:0] carryInto;

  ppa_column_pg #(.N(N), .USE_XOR_PROP(USE_XOR_PROP)) uColumns (
    .opA(opA), .opB(opB), .colGen(colGen), .colProp(colProp)
  );

  // Shift the columns up one place and insert the carry-in column at index 0.
  generate
    if (N > 1) begin : g_leaves
      assign leafGen  = {colGen[N-2:0], carryIn};
      assign leafProp = {colProp[N-2:0], 1'b0};
    end else begin : g_leafOne
      assign leafGen  = carryIn;
      assign leafProp = 1'b0;
    end
  endgenerate

  ppa_prefix_tree #(.N(N)) uTree (
    .leafGen(leafGen), .leafProp(leafProp), .spanGen(carryInto)
  );

  ppa_sum_stage #(.N(N)) uSum (
    .opA(opA), .opB(opB), .carryInto(carryInto),
    .topGen(colGen[N-1]), .topProp(colProp[N-1]),
    .sum(sum), .carryOut(carryOut)
  );

  always_comb begin
    assert_sum_matches_R1: assert ({carryOut, sum} ==
        ({1'b0, opA} + {1'b0, opB} + {{N{1'b0}}, carryIn}))
      else $error("adder result differs from arithmetic sum");
    if (opA == '0 && opB == '0) begin
      assert_carry_column_R3: assert (sum == {{(N-1){1'b0}}, carryIn} && !carryOut)
        else $error("carry-in column not reflected in bit 0");
    end
    if (opA[N-1] && opB[N-1]) begin
      assert_top_generate_R5: assert (carryOut)
        else $error("top column generates but carryOut is low");
    end
  end

endmodule

// File: tb/sim_ppa_adder.sv
module sim_ppa_adder;

  localparam int W = 16;
  localparam int NV = 10;
  // {opA, opB, carryIn, expected sum, expected carryOut}
  localparam logic [49:0] VECS [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b0, 16'hFFFE, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1},
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
    {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0},
    {16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1},
    {16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] a16, b16, s16, s16x;
  logic cin16, c16, c16x;
  logic [3:0] a4, b4, s4;
  logic cin4, c4;

  ppa_adder #(.N(W), .USE_XOR_PROP(1'b0)) u0 (
    .opA(a16), .opB(b16), .carryIn(cin16), .sum(s16), .carryOut(c16));
  ppa_adder #(.N(W), .USE_XOR_PROP(1'b1)) uXor (
    .opA(a16), .opB(b16), .carryIn(cin16), .sum(s16x), .carryOut(c16x));
  ppa_adder #(.N(4), .USE_XOR_PROP(1'b0)) uSmall (
    .opA(a4), .opB(b4), .carryIn(cin4), .sum(s4), .carryOut(c4));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply16(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(posedge clk);
    a16 = a; b16 = b; cin16 = c;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [16:0] ref17;
    logic [W-1:0] saveS;
    a16 = '0; b16 = '0; cin16 = 1'b0;
    a4 = '0; b4 = '0; cin4 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3: quiet inputs during reset give a zero result
    check("R3 reset-state sum", {c16, s16}, 17'h0);
    rst = 1'b0;

    // R1/R4/R5: corner vector table
    for (int i = 0; i < NV; i++) begin
      apply16(VECS[i][49:34], VECS[i][33:18], VECS[i][17]);
      check("R1 table vector", {c16, s16}, {VECS[i][0], VECS[i][16:1]});
    end

    // R3: carry-in alone lands in bit 0
    apply16(16'h0000, 16'h0000, 1'b1);
    check("R3 carry-in column", {c16, s16}, 17'h00001);

    // R4: carry from carry-in crosses every column
    apply16(16'hFFFF, 16'h0000, 1'b1);
    check("R4 full carry chain", {c16, s16}, 17'h10000);

    // R5: top column generate sets carryOut
    apply16(16'h8000, 16'h8000, 1'b1);
    check("R5 top generate", {c16, s16}, 17'h10001);

    // R6: flipping the top operand bit leaves lower sum bits unchanged
    apply16(16'h3C5A, 16'h0F0F, 1'b1);
    saveS = s16;
    apply16(16'hBC5A, 16'h0F0F, 1'b1);
    check("R6 lower bits independent of top", {2'b0, s16[W-2:0]}, {2'b0, saveS[W-2:0]});

    // R1/R2: random sweep, OR and XOR propagate variants agree
    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      if (i % 4 == 0) rb = ~ra;  // long propagate chains
      apply16(ra, rb, rc);
      ref17 = {1'b0, ra} + {1'b0, rb} + {16'b0, rc};
      check("R1 random vector", {c16, s16}, ref17);
      check("R2 xor-prop variant", {c16x, s16x}, ref17);
    end

    // R7: exhaustive N=4
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        for (int c = 0; c < 2; c++) begin
          @(posedge clk);
          a4 = 4'(x); b4 = 4'(y); cin4 = 1'(c);
          @(negedge clk);
          check("R7 exhaustive N=4", {12'b0, c4, s4}, 17'(x + y + c));
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule